// File: doc/BRIEF.md
# Serial-to-Parallel Shift Register with Holding Stage

This block turns a serial bit stream into a parallel word. Bits enter one at a time on the rising edge of a shift clock and march down a chain of stages. A separate storage clock copies the whole chain, in one step, into a holding register that drives the parallel outputs. Because the two clocks are independent, new data can be shifted in while the outputs keep showing the previous word. The outputs then change all at once when the storage clock rises.

The last stage of the chain is also brought out as a cascade output. Feeding that output into the serial input of a second copy, with the clocks shared, builds a wider converter. Each register bank has its own active-low asynchronous clear, and each clear dominates its clock. The parallel outputs are always driven.

Top module: `sipo_latch_stage`

## Requirements
- R1: On each rising edge of `sh_clk` with `sh_clr_n` high, stage 0 takes `ser_in` and stage i takes the old value of stage i-1. Bits shifted in most-significant first land with bit i in stage i after WIDTH edges.
- R2: `casc_out` always equals the last shift stage (stage WIDTH-1), so a bit reaches it WIDTH shift edges after it entered.
- R3: On each rising edge of `st_clk` with `st_clr_n` high, `par_out[i]` loads shift stage i for every i at once. Between storage edges `par_out` holds its value, whatever the shift chain does.
- R4: While `sh_clr_n` is low, every shift stage and `casc_out` are 0 at once, even if `sh_clk` pulses, and `par_out` is left unchanged.
- R5: While `st_clr_n` is low, `par_out` is 0 at once, even if `st_clk` pulses, and the shift stages keep their contents.
- R6: With both clocks driven by the same edge, `par_out` after that edge shows the shift contents from just before it, one edge behind the chain.
- R7: Two copies chained through `casc_out` with shared clocks take 16 bits, most-significant first. After one storage edge the second copy's `par_out` holds bits 15..8 and the first copy's holds bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data entering shift stage 0 |
| sh_clk | input | 1 | Shift clock, rising edge active |
| st_clk | input | 1 | Storage clock, rising edge active |
| sh_clr_n | input | 1 | Active-low asynchronous clear of the shift chain |
| st_clr_n | input | 1 | Active-low asynchronous clear of the storage register |
| par_out | output | WIDTH | Storage register contents, bit i from shift stage i |
| casc_out | output | 1 | Last shift stage, for feeding a following copy |

## Verification
The hardest case to reach is a clear that arrives while its clock is still pulsing, with the other bank holding data that must survive. The stimulus first fills both banks with a known pattern. It then holds one clear low across real clock pulses, releases it, and brings the untouched state out through a later storage edge or the cascade output. The tied-clock lag is reached by gating both clocks from one source in the same cycle, starting from a chain whose contents differ from the storage contents.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int unsigned SIPO_DEF_WIDTH = 8;
    localparam int unsigned SIPO_MIN_WIDTH = 2;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stages,
    output logic             tail
);
    localparam int unsigned LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t chain_d;
    chain_t chain_q;

    // next state: new bit at stage 0, everything else moves one step on
    always_comb begin
        chain_d = chain_q;
        chain_d.bits[0] = din;
        for (int i = 1; i < WIDTH; i++) begin
            chain_d.bits[i] = chain_q.bits[i-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign stages = chain_q.bits;
    assign tail   = chain_q.bits[LAST];
endmodule

// File: rtl/sipo_store_bank.sv
module sipo_store_bank #(
    parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] load_in,
    output logic [WIDTH-1:0] held
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    // every bit loads its own shift stage in parallel
    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < WIDTH; i++) begin
            bank_d.bits[i] = load_in[i];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign held = bank_q.bits;
endmodule

// File: rtl/sipo_latch_stage.sv
module sipo_latch_stage #(
    parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
    input  logic             ser_in,
    input  logic             sh_clk,
    input  logic             st_clk,
    input  logic             sh_clr_n,
    input  logic             st_clr_n,
    output logic [WIDTH-1:0] par_out,
    output logic             casc_out
);
    logic [WIDTH-1:0] shift_bits;

    sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (sh_clk),
        .clr_n  (sh_clr_n),
        .din    (ser_in),
        .stages (shift_bits),
        .tail   (casc_out)
    );

    sipo_store_bank #(.WIDTH(WIDTH)) u_bank (
        .clk     (st_clk),
        .clr_n   (st_clr_n),
        .load_in (shift_bits),
        .held    (par_out)
    );
endmodule

// File: rtl/sipo_chk.sv
module sipo_chk #(
    parameter int unsigned W = sipo_pkg::SIPO_DEF_WIDTH
) (
    input logic         sh_clk,
    input logic         st_clk,
    input logic         sh_clr_n,
    input logic         st_clr_n,
    input logic         ser_in,
    input logic [W-1:0] sh_q,
    input logic [W-1:0] par_out,
    input logic         casc_out
);
    // set once an edge has happened since the last clear
    logic sh_armed;
    logic st_armed;
    logic [W-1:0] snap;

    always_ff @(posedge sh_clk or negedge sh_clr_n) begin
        if (!sh_clr_n) sh_armed <= 1'b0;
        else           sh_armed <= 1'b1;
    end

    always_ff @(posedge st_clk or negedge st_clr_n) begin
        if (!st_clr_n) st_armed <= 1'b0;
        else           st_armed <= 1'b1;
    end

    always_ff @(posedge st_clk) begin
        snap <= sh_q;
    end

    // R1 and R2: stage 0 holds the last serial bit, the tail the old stage W-2
    a_r1_shift_step: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
        sh_armed |-> (sh_q[0] == $past(ser_in)) && (casc_out == $past(sh_q[W-2])));

    // R3: after a storage edge the outputs show the chain seen at that edge
    a_r3_store_load: assert property (@(negedge st_clk) disable iff (!st_clr_n)
        st_armed |-> par_out == snap);

    // R4: shift clear overrides the shift clock
    a_r4_shift_clear: assert property (@(posedge sh_clk)
        !sh_clr_n |-> (sh_q == '0) && !casc_out);

    // R5: storage clear overrides the storage clock
    a_r5_store_clear: assert property (@(posedge st_clk)
        !st_clr_n |-> par_out == '0);
endmodule

bind sipo_latch_stage sipo_chk #(.W(WIDTH)) u_chk (
    .sh_clk   (sh_clk),
    .st_clk   (st_clk),
    .sh_clr_n (sh_clr_n),
    .st_clr_n (st_clr_n),
    .ser_in   (ser_in),
    .sh_q     (shift_bits),
    .par_out  (par_out),
    .casc_out (casc_out)
);

// File: tb/sim_sipo_latch_stage.sv
module sim_sipo_latch_stage;
    logic clk = 1'b0;
    logic sh_en = 1'b0, st_en = 1'b0;
    logic ser = 1'b0;
    logic sh_clr_n = 1'b0, st_clr_n = 1'b0;
    logic sh_clk, st_clk;
    logic [7:0] p0, p1;
    logic c0, c1;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign sh_clk = clk & sh_en;
    assign st_clk = clk & st_en;

    sipo_latch_stage #(.WIDTH(8)) u0 (
        .ser_in(ser), .sh_clk(sh_clk), .st_clk(st_clk),
        .sh_clr_n(sh_clr_n), .st_clr_n(st_clr_n),
        .par_out(p0), .casc_out(c0));
    sipo_latch_stage #(.WIDTH(8)) u1 (
        .ser_in(c0), .sh_clk(sh_clk), .st_clk(st_clk),
        .sh_clr_n(sh_clr_n), .st_clr_n(st_clr_n),
        .par_out(p1), .casc_out(c1));

    localparam logic [15:0] VEC [4] = '{16'hA5C3, 16'h0001, 16'h8000, 16'h7E18};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sh_step(input logic b);
        @(negedge clk); ser = b; sh_en = 1'b1;
        @(negedge clk); sh_en = 1'b0;
    endtask

    task automatic st_step();
        @(negedge clk); st_en = 1'b1;
        @(negedge clk); st_en = 1'b0;
    endtask

    task automatic both_step(input logic b);
        @(negedge clk); ser = b; sh_en = 1'b1; st_en = 1'b1;
        @(negedge clk); sh_en = 1'b0; st_en = 1'b0;
    endtask

    task automatic load8(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) sh_step(v[i]);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state, clears held low
        repeat (2) @(negedge clk);
        check("R4 reset casc", {15'd0, c0}, 16'd0);
        check("R5 reset par", {p1, p0}, 16'd0);
        @(negedge clk); sh_clr_n = 1'b1; st_clr_n = 1'b1;

        // vector table: chained 16-bit words
        for (int k = 0; k < 4; k++) begin
            for (int j = 15; j >= 0; j--) sh_step(VEC[k][j]);
            check("R2 casc u0", {15'd0, c0}, {15'd0, VEC[k][7]});
            check("R2 casc u1", {15'd0, c1}, {15'd0, VEC[k][15]});
            st_step();
            check("R7 chained word", {p1, p0}, VEC[k]);
        end

        // R3: outputs hold while the chain moves
        repeat (3) sh_step(1'b1);
        check("R3 hold", {p1, p0}, VEC[3]);

        // R4: shift clear overrides clock, storage untouched
        @(negedge clk); sh_clr_n = 1'b0;
        #2 check("R4 casc cleared", {15'd0, c0}, 16'd0);
        sh_step(1'b1);
        check("R4 clock ignored", {14'd0, c1, c0}, 16'd0);
        check("R4 par kept", {p1, p0}, VEC[3]);
        @(negedge clk); sh_clr_n = 1'b1;
        st_step();
        check("R4 chain zero", {p1, p0}, 16'd0);

        // R1: shift order and single step
        load8(8'h96);
        st_step();
        check("R1 load 96", {8'd0, p0}, 16'h0096);
        sh_step(1'b1);
        st_step();
        check("R1 one step", {8'd0, p0}, 16'h002D);

        // R5: storage clear, chain kept
        @(negedge clk); st_clr_n = 1'b0;
        #2 check("R5 par cleared", {p1, p0}, 16'd0);
        st_step();
        check("R5 clock ignored", {p1, p0}, 16'd0);
        @(negedge clk); st_clr_n = 1'b1;
        st_step();
        check("R5 chain kept", {8'd0, p0}, 16'h002D);

        // R6: tied clocks lag one edge
        load8(8'hA5);
        check("R2 tail bit", {15'd0, c0}, 16'd1);
        st_step();
        check("R6 preload", {8'd0, p0}, 16'h00A5);
        both_step(1'b0);
        check("R6 lag 1", {8'd0, p0}, 16'h00A5);
        both_step(1'b1);
        check("R6 lag 2", {8'd0, p0}, 16'h004A);
        st_step();
        check("R6 catch up", {8'd0, p0}, 16'h0095);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule